// File: doc/BRIEF.md
# PCI Interrupt Bridge with Source Masking

This block turns on-chip interrupt activity into the PCI INTA request and turns PCI system errors into a local interrupt. The interrupt level vector of the first processor is OR-folded into a single line. That line is bit 0 of a device interrupt vector, and the external device lines fill the remaining bits. Every bit of the vector has its own enable. A force bit can drive INTA no matter what the sources and enables are. The combined request is registered in the system clock domain and then sampled by a two-flop stage in the PCI clock domain, which drives the open-drain, active-low INTA pin.

The active-low, asynchronous SERR input is synchronized, and its falling edge sets a sticky status flag. Software clears the flag by writing 1 to it. When the system-error interrupt enable is set, the flag raises the local interrupt. A small APB slave holds the control and status registers. The block also produces the PCI-domain reset. That reset asserts at once from the system reset and releases on the third PCI clock edge after the system reset deasserts.

Top module: `pci_irq_bridge`

## Requirements
- R1: The interrupt level vector `irl_i` is OR-reduced to device bit 0. With enable bit 0 set, any nonzero `irl_i` makes INTA active.
- R2: Device bits 1..DEV_W-1 come from `ext_irq_i[0..DEV_W-2]`. Each device bit k passes to INTA only while control bit k (offset 0x00, bits [DEV_W-1:0], 1 = pass) is set.
- R3: A source whose enable bit is clear has no effect. INTA stays released while only disabled sources are active.
- R4: Control bit 16 (force) makes INTA active whatever the sources and enables are. Clearing it releases INTA when no enabled source is active.
- R5: INTA is open drain and active low. While it is active, `inta_oe_o` = 1 and `inta_n_o` = 0. Otherwise `inta_oe_o` = 0 and `inta_n_o` = 1. The request is registered on `clk` and then passes through two `pci_clk` flops.
- R6: A falling edge of the synchronized `serr_n_i` sets status bit 0 (offset 0x04). The bit stays set until software writes 1 to it. Writing 0 leaves it unchanged.
- R7: `apb_irq_o` is high exactly while status bit 0 and control bit 17 (system-error interrupt enable) are both set.
- R8: `pci_rst_n_o` goes low as soon as `rst_n` is low. After `rst_n` rises, it goes high on the third rising `pci_clk` edge.
- R9: After reset, the control register reads 0, status bit 0 reads 0, INTA is released and `apb_irq_o` is low.
- R10: The control register reads back its enable, force and enable-interrupt fields. Status bits [15:8] read DEV_W. Any other offset reads 0.
- R11: SERR held low sets the status bit only once. A clear done while SERR stays low remains cleared until a new falling edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and APB clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| pci_clk | input | 1 | PCI clock |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| irl_i | input | IRL_W | Interrupt level vector of the first processor |
| ext_irq_i | input | DEV_W-1 | External device interrupt lines for bits 1 and up |
| serr_n_i | input | 1 | PCI system error, active low, asynchronous |
| inta_n_o | output | 1 | INTA pin value, low when active |
| inta_oe_o | output | 1 | INTA output enable, high only while active |
| apb_irq_o | output | 1 | Local system-error interrupt |
| pci_rst_n_o | output | 1 | PCI-domain reset, active low |

## Verification
The assertions assume that `irl_i`, `ext_irq_i` and the APB signals are synchronous to `clk`, and that `serr_n_i` is the only asynchronous input. They also assume that APB transfers follow the setup-then-access order. The stimulus drives every synchronous input on the falling edge of `clk`, and drives SERR at arbitrary times. Because the PCI path crosses clock domains, INTA is sampled only after several PCI clock edges. The reset-release check toggles `rst_n` away from any `pci_clk` edge, so the three-edge count is unambiguous.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;
    // register offsets
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_STATUS = 8'h04;
    // control field positions
    localparam int CTRL_FORCE_BIT   = 16;
    localparam int CTRL_SERR_IE_BIT = 17;
    // status field positions
    localparam int STAT_SERR_BIT    = 0;
    localparam int STAT_CAP_LSB     = 8;
    localparam int STAT_CAP_W       = 8;
endpackage

// File: rtl/pci_rst_sync.sv
module pci_rst_sync #(
    parameter int DEPTH = 3
) (
    input  logic pci_clk,
    input  logic arst_n,
    output logic rst_n_o
);
    logic [DEPTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[DEPTH-2:0], 1'b1};
    end

    always_ff @(posedge pci_clk or negedge arst_n) begin
        if (!arst_n) stage_q <= '0;
        else         stage_q <= stage_d;
    end

    assign rst_n_o = stage_q[DEPTH-1];
endmodule

// File: rtl/serr_detect.sv
module serr_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic serr_n_i,
    output logic set_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.sync = {det_q.sync[SYNC_STAGES-2:0], serr_n_i};
        det_d.prev = det_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '1;
        else        det_q <= det_d;
    end

    // falling edge of the synchronized level
    assign set_o = det_q.prev & ~det_q.sync[SYNC_STAGES-1];

    AST_SET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        set_o |=> !set_o); // R11
endmodule

// File: rtl/bridge_regs.sv
module bridge_regs
    import pci_irq_pkg::*;
#(
    parameter int DEV_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              serr_set_i,
    output logic [DEV_W-1:0]  irq_en_o,
    output logic              force_o,
    output logic              serr_ie_o,
    output logic              serr_stat_o
);
    typedef struct packed {
        logic [DEV_W-1:0] en;
        logic             frc;
        logic             ie;
        logic             stat;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl, wr_stat, clr_stat;

    always_comb begin
        wr_ctrl  = psel & penable & pwrite & (paddr == ADDR_W'(OFS_CTRL));
        wr_stat  = psel & penable & pwrite & (paddr == ADDR_W'(OFS_STATUS));
        clr_stat = wr_stat & pwdata[STAT_SERR_BIT];
        r_d      = r_q;
        if (wr_ctrl) begin
            r_d.en  = pwdata[DEV_W-1:0];
            r_d.frc = pwdata[CTRL_FORCE_BIT];
            r_d.ie  = pwdata[CTRL_SERR_IE_BIT];
        end
        if (clr_stat)   r_d.stat = 1'b0;
        if (serr_set_i) r_d.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        prdata = '0;
        if (paddr == ADDR_W'(OFS_CTRL)) begin
            prdata[DEV_W-1:0]        = r_q.en;
            prdata[CTRL_FORCE_BIT]   = r_q.frc;
            prdata[CTRL_SERR_IE_BIT] = r_q.ie;
        end else if (paddr == ADDR_W'(OFS_STATUS)) begin
            prdata[STAT_SERR_BIT]                       = r_q.stat;
            prdata[STAT_CAP_LSB +: STAT_CAP_W]          = STAT_CAP_W'(DEV_W);
        end
    end

    wire unused_wdata = ^pwdata;

    assign irq_en_o    = r_q.en;
    assign force_o     = r_q.frc;
    assign serr_ie_o   = r_q.ie;
    assign serr_stat_o = r_q.stat;

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.stat && !clr_stat) |=> r_q.stat); // R6
    AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stat && !serr_set_i) |=> !r_q.stat); // R6
    AST_STAT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.stat) |-> $past(serr_set_i)); // R11
endmodule

// File: rtl/inta_gen.sv
module inta_gen #(
    parameter int DEV_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pci_clk,
    input  logic             pci_rst_n,
    input  logic [DEV_W-1:0] dev_vec_i,
    input  logic [DEV_W-1:0] en_i,
    input  logic             force_i,
    output logic             inta_n_o,
    output logic             inta_oe_o
);
    // system-domain request register
    logic req_d, req_q;

    always_comb begin
        req_d = force_i | (|(dev_vec_i & en_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    // PCI-domain sampling stages
    logic [SYNC_STAGES-1:0] smp_d, smp_q;

    always_comb begin
        smp_d = {smp_q[SYNC_STAGES-2:0], req_q};
    end

    always_ff @(posedge pci_clk or negedge pci_rst_n) begin
        if (!pci_rst_n) smp_q <= '0;
        else            smp_q <= smp_d;
    end

    assign inta_oe_o = smp_q[SYNC_STAGES-1];
    assign inta_n_o  = ~smp_q[SYNC_STAGES-1];

    AST_FORCE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> req_q); // R4
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && ((dev_vec_i & en_i) == '0)) |=> !req_q); // R3
    AST_ENABLED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_vec_i & en_i) != '0) |=> req_q); // R2
endmodule

// File: rtl/pci_irq_bridge.sv
module pci_irq_bridge
    import pci_irq_pkg::*;
#(
    parameter int DEV_W      = 4,
    parameter int IRL_W      = 15,
    parameter int ADDR_W     = 8,
    parameter int RST_DEPTH  = 3,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pci_clk,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [IRL_W-1:0]  irl_i,
    input  logic [DEV_W-2:0]  ext_irq_i,
    input  logic              serr_n_i,
    output logic              inta_n_o,
    output logic              inta_oe_o,
    output logic              apb_irq_o,
    output logic              pci_rst_n_o
);
    logic [DEV_W-1:0] dev_vec, irq_en;
    logic             frc, serr_ie, serr_stat, serr_set;

    assign dev_vec = {ext_irq_i, |irl_i};

    pci_rst_sync #(.DEPTH(RST_DEPTH)) u_rst (
        .pci_clk (pci_clk),
        .arst_n  (rst_n),
        .rst_n_o (pci_rst_n_o)
    );

    serr_detect #(.SYNC_STAGES(SYNC_DEPTH)) u_serr (
        .clk      (clk),
        .rst_n    (rst_n),
        .serr_n_i (serr_n_i),
        .set_o    (serr_set)
    );

    bridge_regs #(.DEV_W(DEV_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .psel        (psel),
        .penable     (penable),
        .pwrite      (pwrite),
        .paddr       (paddr),
        .pwdata      (pwdata),
        .prdata      (prdata),
        .serr_set_i  (serr_set),
        .irq_en_o    (irq_en),
        .force_o     (frc),
        .serr_ie_o   (serr_ie),
        .serr_stat_o (serr_stat)
    );

    inta_gen #(.DEV_W(DEV_W), .SYNC_STAGES(SYNC_DEPTH)) u_inta (
        .clk       (clk),
        .rst_n     (rst_n),
        .pci_clk   (pci_clk),
        .pci_rst_n (pci_rst_n_o),
        .dev_vec_i (dev_vec),
        .en_i      (irq_en),
        .force_i   (frc),
        .inta_n_o  (inta_n_o),
        .inta_oe_o (inta_oe_o)
    );

    assign apb_irq_o = serr_stat & serr_ie;

    AST_IRQ_OFF_WITHOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_stat |-> !apb_irq_o); // R7
endmodule

// File: tb/pci_irq_bridge_tb.sv
module pci_irq_bridge_tb;
    localparam int DEV_W = 4;
    localparam int IRL_W = 15;

    logic        clk = 1'b0, pci_clk = 1'b0, rst_n = 1'b0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic [IRL_W-1:0] irl = '0;
    logic [DEV_W-2:0] ext = '0;
    logic        serr_n = 1'b1;
    logic        inta_n, inta_oe, apb_irq, pci_rst_n;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;      // 200 MHz
    always #15  pci_clk = ~pci_clk;

    pci_irq_bridge #(.DEV_W(DEV_W), .IRL_W(IRL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pci_clk(pci_clk),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata), .irl_i(irl), .ext_irq_i(ext),
        .serr_n_i(serr_n), .inta_n_o(inta_n), .inta_oe_o(inta_oe),
        .apb_irq_o(apb_irq), .pci_rst_n_o(pci_rst_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic settle_pci();
        repeat (4) @(posedge pci_clk);
        #1;
    endtask

    task automatic check_inta(input bit active, input string req);
        check(inta_oe == active && inta_n == !active, req, {30'b0, inta_oe, inta_n}, {30'b0, active, !active});
    endtask

    task automatic t_reset_release();
        #1 check(pci_rst_n == 0, "R8 held", {31'b0, pci_rst_n}, 0);
        #100 rst_n = 1;
        repeat (2) @(posedge pci_clk);
        #1 check(pci_rst_n == 0, "R8 two edges", {31'b0, pci_rst_n}, 0);
        @(posedge pci_clk);
        #1 check(pci_rst_n == 1, "R8 third edge", {31'b0, pci_rst_n}, 1);
    endtask

    task automatic t_reset_values();
        logic [31:0] d;
        apb_read(8'h00, d); check(d == 0, "R9 ctrl", d, 0);
        apb_read(8'h04, d); check(d == 32'h0000_0400, "R9 status", d, 32'h0000_0400);
        settle_pci();
        check_inta(0, "R9 inta");
        check(apb_irq == 0, "R9 apb_irq", {31'b0, apb_irq}, 0);
    endtask

    task automatic t_irl_fold();
        apb_write(8'h00, 32'h1);
        @(negedge clk); irl = 15'h0080;
        settle_pci(); check_inta(1, "R1 one irl bit");
        @(negedge clk); irl = '0;
        settle_pci(); check_inta(0, "R5 released");
        @(negedge clk); irl = 15'h4000;
        settle_pci(); check_inta(1, "R1 top irl bit");
        @(negedge clk); irl = '0;
        settle_pci();
    endtask

    task automatic t_dev_mask();
        apb_write(8'h00, 32'h4);               // only device bit 2
        @(negedge clk); ext = 3'b001;          // device bit 1
        settle_pci(); check_inta(0, "R3 bit1 disabled");
        @(negedge clk); ext = '0; irl = 15'h0001;
        settle_pci(); check_inta(0, "R3 irl disabled");
        @(negedge clk); irl = '0; ext = 3'b010; // device bit 2
        settle_pci(); check_inta(1, "R2 bit2 enabled");
        apb_write(8'h00, 32'h8);
        settle_pci(); check_inta(0, "R2 bit2 now disabled");
        @(negedge clk); ext = 3'b100;          // device bit 3
        settle_pci(); check_inta(1, "R2 bit3 enabled");
        @(negedge clk); ext = '0;
        settle_pci();
    endtask

    task automatic t_force();
        apb_write(8'h00, 32'h0001_0000);
        settle_pci(); check_inta(1, "R4 force");
        apb_write(8'h00, 32'h0);
        settle_pci(); check_inta(0, "R4 force cleared");
    endtask

    task automatic t_serr();
        logic [31:0] d;
        apb_write(8'h00, 32'h0);
        #7 serr_n = 0;
        repeat (6) @(negedge clk);
        apb_read(8'h04, d); check(d[0] == 1, "R6 set", d, 32'h401);
        check(apb_irq == 0, "R7 disabled", {31'b0, apb_irq}, 0);
        apb_write(8'h04, 32'h0);
        apb_read(8'h04, d); check(d[0] == 1, "R6 write0 keeps", d, 32'h401);
        apb_write(8'h04, 32'h1);
        repeat (4) @(negedge clk);
        apb_read(8'h04, d); check(d[0] == 0, "R11 level no reset", d, 32'h400);
        apb_write(8'h00, 32'h0002_0000);
        #1 check(apb_irq == 0, "R7 no flag", {31'b0, apb_irq}, 0);
        #3 serr_n = 1;
        repeat (5) @(negedge clk);
        #3 serr_n = 0;
        repeat (6) @(negedge clk);
        #1 check(apb_irq == 1, "R7 raised", {31'b0, apb_irq}, 1);
        apb_write(8'h04, 32'h1);
        #1 check(apb_irq == 0, "R6 R7 w1c", {31'b0, apb_irq}, 0);
        serr_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        apb_write(8'h00, 32'hFFFF_FFFF);
        apb_read(8'h00, d); check(d == 32'h0003_000F, "R10 ctrl", d, 32'h0003_000F);
        apb_read(8'h08, d); check(d == 0, "R10 unmapped", d, 0);
        apb_write(8'h00, 32'h0);
        settle_pci();
    endtask

    task automatic t_reset_again();
        apb_write(8'h00, 32'h0003_0001);
        #3 rst_n = 0;
        #1 check(pci_rst_n == 0, "R8 immediate", {31'b0, pci_rst_n}, 0);
        #40 rst_n = 1;
        repeat (5) @(posedge pci_clk);
        #1;
        t_reset_values();
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset_release();
        t_reset_values();
        t_irl_fold();
        t_dev_mask();
        t_force();
        t_serr();
        t_readback();
        t_reset_again();
        done = 1;
        report();
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            report();
        end
    end
endmodule